// File: doc/BRIEF.md
# CAN Frame Receive FIFO

This block holds received CAN and CAN FD frames for a controller until software unloads them. A frame arrives word by word on a write port: first a header word, then an identifier word, two reserved words and the payload words. The header carries a word-count field that gives the frame's stored length. The block checks at the header whether the whole frame fits. If it does, the words go into a circular word memory, and the frame becomes visible to the reader once its last word has been written. If it does not fit, the block drops the entire frame and raises an overrun event.

Software drains the memory through a single data register. Each read strobe returns one 32-bit word in arrival order. The block finds frame boundaries from the word-count field of each frame's first word, so it can keep a count of complete frames still stored. Occupancy is reported as words stored, free words, total size and read and write pointers, with empty and full flags. A release command throws away everything stored.

Top module: `can_rx_fifo`

## Requirements
- R1: After reset, the following all read zero: rd_data, frame_cnt, rd_ptr, wr_ptr, ovr_pulse, ovr_flag, nonempty, full and rx_total. In the same state, empty is 1 and free_words and size_words both equal DEPTH.
- R2: The word-count field is bits [15:11] of a frame's first word (fw_sof high), and the frame occupies that value plus one words. The frame is accepted when the stored word count plus its length is at most DEPTH. Its words are stored at consecutive ring positions starting at wr_ptr. It becomes visible in the cycle after its last word is written: frame_cnt and the stored words rise, and nonempty is set.
- R3: A frame that does not fit is dropped whole, and stored contents and pointers are unaffected by any of its words. ovr_pulse is high for exactly the one cycle after its header. ovr_flag is set and stays set until cmd_clr_ovr; a drop in the same cycle as cmd_clr_ovr wins.
- R4: Each rd_strobe with data stored returns the oldest stored word on rd_data in the next cycle. rd_ptr advances by one modulo DEPTH. rd_data holds its value when no strobe is given.
- R5: A read that starts a frame takes the frame length from that word's bits [15:11] plus one. frame_cnt decrements on the read that removes the frame's last word.
- R6: empty is 1 exactly when frame_cnt is zero. nonempty is set by an accepted frame and cleared when the frame count drops to zero.
- R7: A read strobe while nothing is stored makes rd_data zero and changes no pointer or count.
- R8: full is 1 when the stored words equal DEPTH. free_words is DEPTH minus the stored words. wr_ptr is (rd_ptr + stored words) modulo DEPTH.
- R9: cmd_release clears rd_ptr, the stored words, the frame count, the read-side remaining count and nonempty, and it discards a frame being written. rx_total and ovr_flag keep their values, and read strobes and frame words in that cycle have no effect.
- R10: A frame completion and a data read in the same cycle both take effect, and the stored words and frame count change by the net amount.
- R11: A header arriving while a frame is partly written abandons the partial frame. A non-header word with no frame in progress is ignored.
- R12: rx_total counts accepted frames, wraps at 2^TOT_W, and is not cleared by cmd_release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fw_valid | input | 1 | Frame word present on fw_data |
| fw_sof | input | 1 | Word is a frame's first (header) word |
| fw_data | input | 32 | Frame word |
| rd_strobe | input | 1 | Read of the data register |
| cmd_release | input | 1 | Discard all stored contents |
| cmd_clr_ovr | input | 1 | Clear the sticky overrun flag |
| rd_data | output | 32 | Word returned by the last read |
| frame_cnt | output | CNT_W | Complete frames stored |
| empty | output | 1 | No frame stored |
| nonempty | output | 1 | Receive-not-empty status |
| full | output | 1 | Stored words equal capacity |
| rd_ptr | output | PTR_W | Read position in words |
| wr_ptr | output | PTR_W | Write position in words |
| free_words | output | CNT_W | Free space in words |
| size_words | output | CNT_W | Capacity in words |
| ovr_pulse | output | 1 | One-cycle overrun event |
| ovr_flag | output | 1 | Sticky overrun status |
| rx_total | output | TOT_W | Free-running accepted-frame counter |

## Verification
The bench builds the block with DEPTH of 32 words and TOT_W of 4. At that size, one maximum 20-word frame followed by a second one reaches the overrun path at once. Frame mixes run the ring to full and wrap both pointers many times within a few thousand cycles. The accepted-frame counter wraps after sixteen frames, so its roll-over is exercised as well. Random phases alternate slow and fast reading, which puts frame completion and reads in the same cycle, including on the last word of a frame.

// File: rtl/can_rxf_pkg.sv
package can_rxf_pkg;
  localparam int WORD_W = 32;
  // word-count field inside a frame's first word
  localparam int WC_LSB = 11;
  localparam int WC_W   = 5;
  localparam int LEN_W  = WC_W + 1;

  // stored frame length in words, taken from its first word
  function automatic logic [LEN_W-1:0] frame_words(input logic [WORD_W-1:0] hdr);
    return {1'b0, hdr[WC_LSB +: WC_W]} + LEN_W'(1);
  endfunction

  // ring addition for a < depth, b <= depth
  function automatic int unsigned ring_add(input int unsigned a, input int unsigned b,
                                           input int unsigned depth);
    int unsigned s;
    s = a + b;
    return (s >= depth) ? s - depth : s;
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int DEPTH  = 64,
  parameter int WORD_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxf_ingress.sv
module rxf_ingress import can_rxf_pkg::*; #(
  parameter int DEPTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fw_valid,
  input  logic              fw_sof,
  input  logic [WORD_W-1:0] fw_data,
  input  logic              release_i,
  input  logic [CNT_W-1:0]  used_words,
  input  logic [PTR_W-1:0]  wr_head,
  output logic              st_we,
  output logic [PTR_W-1:0]  st_addr,
  output logic [WORD_W-1:0] st_data,
  output logic              commit_evt,
  output logic [CNT_W-1:0]  commit_words,
  output logic              drop_evt
);
  logic             active_q, keep_q;
  logic [LEN_W-1:0] left_q, len_q, off_q;
  logic [LEN_W-1:0] hdr_len;
  logic             fits, start, cont;

  always_comb begin
    hdr_len      = frame_words(fw_data);
    fits         = (32'(used_words) + 32'(hdr_len)) <= 32'(DEPTH);
    start        = fw_valid && fw_sof && !release_i;
    cont         = fw_valid && !fw_sof && active_q && !release_i;
    st_we        = (start && fits) || (cont && keep_q);
    st_addr      = start ? wr_head
                         : PTR_W'(ring_add(32'(wr_head), 32'(off_q), DEPTH));
    st_data      = fw_data;
    drop_evt     = start && !fits;
    commit_evt   = (start && fits && hdr_len == LEN_W'(1)) ||
                   (cont && keep_q && left_q == LEN_W'(1));
    commit_words = start ? CNT_W'(hdr_len) : CNT_W'(len_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      keep_q   <= 1'b0;
      left_q   <= '0;
      len_q    <= '0;
      off_q    <= '0;
    end else if (release_i) begin
      active_q <= 1'b0;
    end else if (start) begin
      active_q <= hdr_len > LEN_W'(1);
      keep_q   <= fits;
      left_q   <= hdr_len - LEN_W'(1);
      len_q    <= hdr_len;
      off_q    <= LEN_W'(1);
    end else if (cont) begin
      left_q <= left_q - LEN_W'(1);
      off_q  <= off_q + LEN_W'(1);
      if (left_q == LEN_W'(1)) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rxf_egress.sv
module rxf_egress import can_rxf_pkg::*; #(
  parameter int DEPTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_strobe,
  input  logic              release_i,
  input  logic              have_words,
  input  logic [WORD_W-1:0] head_word,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [WORD_W-1:0] rd_data,
  output logic              pop_evt,
  output logic              frame_done_evt
);
  logic [LEN_W-1:0] rem_q, rem_now, rem_after;

  always_comb begin
    pop_evt        = rd_strobe && have_words && !release_i;
    rem_now        = (rem_q == '0) ? frame_words(head_word) : rem_q;
    rem_after      = rem_now - LEN_W'(1);
    frame_done_evt = pop_evt && (rem_after == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      rem_q   <= '0;
      rd_data <= '0;
    end else if (release_i) begin
      rd_ptr <= '0;
      rem_q  <= '0;
    end else if (rd_strobe) begin
      if (have_words) begin
        rd_data <= head_word;
        rd_ptr  <= PTR_W'(ring_add(32'(rd_ptr), 32'd1, DEPTH));
        rem_q   <= rem_after;
      end else begin
        rd_data <= '0;
      end
    end
  end
endmodule

// File: rtl/can_rx_fifo.sv
module can_rx_fifo import can_rxf_pkg::*; #(
  parameter int DEPTH = 64,
  parameter int TOT_W = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fw_valid,
  input  logic              fw_sof,
  input  logic [WORD_W-1:0] fw_data,
  input  logic              rd_strobe,
  input  logic              cmd_release,
  input  logic              cmd_clr_ovr,
  output logic [WORD_W-1:0] rd_data,
  output logic [CNT_W-1:0]  frame_cnt,
  output logic              empty,
  output logic              nonempty,
  output logic              full,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [CNT_W-1:0]  free_words,
  output logic [CNT_W-1:0]  size_words,
  output logic              ovr_pulse,
  output logic              ovr_flag,
  output logic [TOT_W-1:0]  rx_total
);
  // occupancy and status state
  logic [CNT_W-1:0]  used_q, frames_q;
  logic              nonempty_q, ovr_pulse_q, ovr_flag_q;
  logic [TOT_W-1:0]  total_q;

  // events between the pieces
  logic              st_we;
  logic [PTR_W-1:0]  st_addr;
  logic [WORD_W-1:0] st_data, head_word;
  logic              commit_evt, drop_evt, pop_evt, frame_done_evt;
  logic [CNT_W-1:0]  commit_words;
  logic [PTR_W-1:0]  wr_head;

  assign wr_head = PTR_W'(ring_add(32'(rd_ptr), 32'(used_q), DEPTH));

  rxf_ingress #(.DEPTH(DEPTH)) ingress_i (
    .clk(clk), .rst_n(rst_n), .fw_valid(fw_valid), .fw_sof(fw_sof),
    .fw_data(fw_data), .release_i(cmd_release), .used_words(used_q),
    .wr_head(wr_head), .st_we(st_we), .st_addr(st_addr), .st_data(st_data),
    .commit_evt(commit_evt), .commit_words(commit_words), .drop_evt(drop_evt)
  );

  rxf_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) store_i (
    .clk(clk), .we(st_we), .waddr(st_addr), .wdata(st_data),
    .raddr(rd_ptr), .rdata(head_word)
  );

  rxf_egress #(.DEPTH(DEPTH)) egress_i (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .release_i(cmd_release),
    .have_words(used_q != '0), .head_word(head_word), .rd_ptr(rd_ptr),
    .rd_data(rd_data), .pop_evt(pop_evt), .frame_done_evt(frame_done_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q      <= '0;
      frames_q    <= '0;
      nonempty_q  <= 1'b0;
      ovr_pulse_q <= 1'b0;
      ovr_flag_q  <= 1'b0;
      total_q     <= '0;
    end else begin
      ovr_pulse_q <= drop_evt;
      if (drop_evt)         ovr_flag_q <= 1'b1;
      else if (cmd_clr_ovr) ovr_flag_q <= 1'b0;
      if (cmd_release) begin
        used_q     <= '0;
        frames_q   <= '0;
        nonempty_q <= 1'b0;
      end else begin
        used_q   <= used_q + (commit_evt ? commit_words : '0) - CNT_W'(pop_evt);
        frames_q <= frames_q + CNT_W'(commit_evt) - CNT_W'(frame_done_evt);
        if (commit_evt)
          nonempty_q <= 1'b1;
        else if (frame_done_evt && frames_q == CNT_W'(1))
          nonempty_q <= 1'b0;
      end
      if (commit_evt) total_q <= total_q + TOT_W'(1);
    end
  end

  assign frame_cnt  = frames_q;
  assign empty      = (frames_q == '0);
  assign nonempty   = nonempty_q;
  assign full       = (used_q == CNT_W'(DEPTH));
  assign wr_ptr     = wr_head;
  assign free_words = CNT_W'(DEPTH) - used_q;
  assign size_words = CNT_W'(DEPTH);
  assign ovr_pulse  = ovr_pulse_q;
  assign ovr_flag   = ovr_flag_q;
  assign rx_total   = total_q;
endmodule

// File: rtl/can_rx_fifo_chk.sv
module can_rx_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int TOT_W = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_strobe,
  input logic             cmd_release,
  input logic             empty,
  input logic             nonempty,
  input logic [PTR_W-1:0] rd_ptr,
  input logic [31:0]      rd_data,
  input logic [CNT_W-1:0] frame_cnt,
  input logic [CNT_W-1:0] free_words,
  input logic [CNT_W-1:0] size_words,
  input logic             ovr_pulse,
  input logic             ovr_flag,
  input logic [TOT_W-1:0] rx_total,
  input logic             commit_evt,
  input logic             drop_evt
);
  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
  endfunction

  // R6
  empty_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty == !nonempty);

  // R3
  drop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_evt && drop_evt));

  // R3
  drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (ovr_pulse && ovr_flag));

  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && empty && !cmd_release) |=> (rd_data == '0 && rd_ptr == $past(rd_ptr)));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !empty && !cmd_release) |=> (rd_ptr == next_ptr($past(rd_ptr))));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_release |=> (rd_ptr == '0 && frame_cnt == '0 && free_words == size_words));

  // R8
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_cnt != '0) |-> (free_words < size_words));

  // R12
  total_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_total != $past(rx_total)) |-> (rx_total == $past(rx_total) + TOT_W'(1)));
endmodule

bind can_rx_fifo can_rx_fifo_chk #(.DEPTH(DEPTH), .TOT_W(TOT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .cmd_release(cmd_release),
  .empty(empty), .nonempty(nonempty), .rd_ptr(rd_ptr), .rd_data(rd_data),
  .frame_cnt(frame_cnt), .free_words(free_words), .size_words(size_words),
  .ovr_pulse(ovr_pulse), .ovr_flag(ovr_flag), .rx_total(rx_total),
  .commit_evt(commit_evt), .drop_evt(drop_evt)
);

// File: tb/can_rx_fifo_tb_top.sv
module can_rx_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;
  localparam int TOT_W = 4;
  localparam int PTR_W = 5;
  localparam int CNT_W = 6;

  logic clk, rst_n, fw_valid, fw_sof, rd_strobe, cmd_release, cmd_clr_ovr;
  logic [31:0] fw_data, rd_data;
  logic [CNT_W-1:0] frame_cnt, free_words, size_words;
  logic empty, nonempty, full, ovr_pulse, ovr_flag;
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [TOT_W-1:0] rx_total;

  can_rx_fifo #(.DEPTH(DEPTH), .TOT_W(TOT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .fw_valid(fw_valid), .fw_sof(fw_sof), .fw_data(fw_data),
    .rd_strobe(rd_strobe), .cmd_release(cmd_release), .cmd_clr_ovr(cmd_clr_ovr),
    .rd_data(rd_data), .frame_cnt(frame_cnt), .empty(empty), .nonempty(nonempty),
    .full(full), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .free_words(free_words),
    .size_words(size_words), .ovr_pulse(ovr_pulse), .ovr_flag(ovr_flag),
    .rx_total(rx_total)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int total_checks = 0;
  int bad_checks = 0;
  bit finished = 0;

  // reference model state
  logic [31:0] m_words[$];
  logic [31:0] w_pend[$];
  int m_frames, m_rem, m_rdptr, m_total, w_left;
  bit m_nonempty, m_ovr, m_pulse, w_active, w_keep;
  logic [31:0] m_rdata;

  function automatic int hdr_len(input logic [31:0] w);
    return int'(w[15:11]) + 1;
  endfunction

  function automatic logic [31:0] make_hdr(input int wc);
    logic [31:0] w;
    w = $urandom;
    w[15:11] = wc[4:0];
    return w;
  endfunction

  task automatic chk(input bit ok, input string ctx, input string what,
                     input longint act, input longint exp);
    total_checks++;
    if (!ok) begin
      bad_checks++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", ctx, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string ctx);
    int used;
    used = m_words.size();
    chk(rd_data == m_rdata, ctx, "R4 rd_data", rd_data, m_rdata);
    chk(int'(frame_cnt) == m_frames, ctx, "R5 frame_cnt", frame_cnt, m_frames);
    chk(empty == (m_frames == 0), ctx, "R6 empty", empty, m_frames == 0);
    chk(nonempty == m_nonempty, ctx, "R6 nonempty", nonempty, m_nonempty);
    chk(full == (used == DEPTH), ctx, "R8 full", full, used == DEPTH);
    chk(int'(rd_ptr) == m_rdptr, ctx, "R4 rd_ptr", rd_ptr, m_rdptr);
    chk(int'(wr_ptr) == (m_rdptr + used) % DEPTH, ctx, "R8 wr_ptr", wr_ptr, (m_rdptr + used) % DEPTH);
    chk(int'(free_words) == DEPTH - used, ctx, "R8 free_words", free_words, DEPTH - used);
    chk(int'(size_words) == DEPTH, ctx, "R8 size_words", size_words, DEPTH);
    chk(ovr_pulse == m_pulse, ctx, "R3 ovr_pulse", ovr_pulse, m_pulse);
    chk(ovr_flag == m_ovr, ctx, "R3 ovr_flag", ovr_flag, m_ovr);
    chk(int'(rx_total) == m_total, ctx, "R12 rx_total", rx_total, m_total);
  endtask

  task automatic model_step(input bit fv, input bit sof, input logic [31:0] data,
                            input bit rd, input bit rel, input bit clr);
    bit do_commit;
    int used0, len;
    logic [31:0] w;
    do_commit = 0;
    m_pulse = 0;
    used0 = m_words.size();
    if (rel) begin
      m_words.delete();
      w_pend.delete();
      m_frames = 0; m_rem = 0; m_rdptr = 0; m_nonempty = 0; w_active = 0;
      if (clr) m_ovr = 0;
      return;
    end
    if (fv && sof) begin
      len = hdr_len(data);
      w_pend.delete();
      w_keep = (used0 + len) <= DEPTH;
      if (w_keep) w_pend.push_back(data);
      else m_pulse = 1;
      w_left = len - 1;
      w_active = (len > 1);
      if (w_keep && len == 1) do_commit = 1;
    end else if (fv && w_active) begin
      if (w_keep) w_pend.push_back(data);
      w_left--;
      if (w_left == 0) begin
        w_active = 0;
        if (w_keep) do_commit = 1;
      end
    end
    if (rd) begin
      if (used0 > 0) begin
        w = m_words.pop_front();
        m_rdata = w;
        if (m_rem == 0) m_rem = hdr_len(w);
        m_rem--;
        m_rdptr = (m_rdptr + 1) % DEPTH;
        if (m_rem == 0) begin
          m_frames--;
          if (m_frames == 0) m_nonempty = 0;
        end
      end else begin
        m_rdata = '0;
      end
    end
    if (do_commit) begin
      foreach (w_pend[i]) m_words.push_back(w_pend[i]);
      w_pend.delete();
      m_frames++;
      m_nonempty = 1;
      m_total = (m_total + 1) % (1 << TOT_W);
    end
    if (clr) m_ovr = 0;
    if (m_pulse) m_ovr = 1;
  endtask

  // one clock: drive at the falling edge, compare at the next falling edge
  task automatic cyc(input bit fv, input bit sof, input logic [31:0] data,
                     input bit rd, input bit rel, input bit clr, input string ctx);
    fw_valid = fv; fw_sof = sof; fw_data = data;
    rd_strobe = rd; cmd_release = rel; cmd_clr_ovr = clr;
    model_step(fv, sof, data, rd, rel, clr);
    @(negedge clk);
    compare_all(ctx);
  endtask

  task automatic send_frame(input int wc, input bit rd_each, input string ctx);
    for (int i = 0; i <= wc; i++)
      cyc(1'b1, i == 0, (i == 0) ? make_hdr(wc) : $urandom, rd_each, 1'b0, 1'b0, ctx);
  endtask

  task automatic idle_reads(input int n, input string ctx);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, ctx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad_checks++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
      $finish;
    end
  end

  initial begin
    int gen_left, rd_pct;
    bit fv, sof, rd, rel, clr;
    logic [31:0] data;
    void'($urandom(32'd20240611));
    fw_valid = 0; fw_sof = 0; fw_data = '0; rd_strobe = 0; cmd_release = 0; cmd_clr_ovr = 0;
    m_frames = 0; m_rem = 0; m_rdptr = 0; m_total = 0; w_left = 0;
    m_nonempty = 0; m_ovr = 0; m_pulse = 0; w_active = 0; w_keep = 0; m_rdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare_all("R1 reset");

    // R7: read with nothing stored
    cyc(0, 0, '0, 1, 0, 0, "R7 empty read");
    // R2: minimal four-word frame, then drain (R4, R5)
    send_frame(3, 0, "R2 accept");
    chk(frame_cnt == 1, "R2", "frame visible", frame_cnt, 1);
    idle_reads(5, "R5 drain");
    // R2: single-word frame and maximum frame
    send_frame(0, 0, "R2 one word");
    send_frame(19, 0, "R2 long frame");
    // R3: next long frame does not fit
    send_frame(19, 0, "R3 overrun");
    chk(ovr_flag == 1, "R3", "sticky flag", ovr_flag, 1);
    cyc(0, 0, '0, 0, 0, 1, "R3 clear flag");
    // R10: completions while reading every cycle
    send_frame(10, 1, "R10 concurrent");
    send_frame(3, 1, "R10 concurrent");
    // R11: abandoned partial frame, then stray word
    cyc(1, 1, make_hdr(7), 0, 0, 0, "R11 abandon");
    cyc(1, 0, $urandom, 0, 0, 0, "R11 abandon");
    send_frame(3, 0, "R11 restart");
    cyc(1, 0, $urandom, 0, 0, 0, "R11 stray word");
    // R9: release while a frame is half written
    cyc(1, 1, make_hdr(5), 0, 0, 0, "R9 release");
    cyc(1, 0, $urandom, 1, 1, 0, "R9 release");
    chk(free_words == DEPTH, "R9", "free after release", free_words, DEPTH);
    cyc(1, 0, $urandom, 0, 0, 0, "R9 after release");
    idle_reads(2, "R9 after release");

    // random phases
    gen_left = 0;
    for (int n = 0; n < 6000; n++) begin
      rd_pct = ((n / 400) % 2 == 1) ? 70 : 15;
      fv = 0; sof = 0; data = '0;
      if ($urandom % 4 != 0) begin
        fv = 1;
        if (gen_left == 0 || $urandom % 60 == 0) begin
          gen_left = int'($urandom % 20);
          sof = 1;
          data = make_hdr(gen_left);
        end else begin
          data = $urandom;
          gen_left--;
        end
      end
      rd  = ($urandom % 100) < rd_pct;
      rel = ($urandom % 400) == 0;
      clr = ($urandom % 50) == 0;
      cyc(fv, sof, data, rd, rel, clr, "random");
    end
    idle_reads(DEPTH + 2, "R6 final drain");
    chk(empty == 1, "R6", "empty after drain", empty, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end
endmodule